// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock using a shift register with polynomial feedback. It works in the plain long-division form: the register starts at zero, each incoming bit enters at the least significant end, and whenever a one leaves the most significant end the low bits of the generator polynomial are XORed into the register. The check width and the polynomial are parameters. The default is a 5-bit check with generator 110101, which is x^5 + x^4 + x^2 + 1.

A start strobe clears the register and selects the mode for the coming frame. In generate mode the user sends only the message bits and marks the last one with an end-of-frame strobe. The block then shifts in the trailing zero bits itself and pulses `done_o` when the remainder is ready to append to the frame. In check mode the user sends the whole received frame, check bits included. One edge after the last bit, `done_o` pulses, and `err_o` reports whether the remainder is nonzero. The result is held until the next start.

Top module: `crc_serial_unit`

## Requirements
- R1: While reset is asserted and after it is released with no start, `rem_o` is all zeros and `done_o` and `err_o` are 0.
- R2: `start_i` clears the register to zero and takes priority over every other activity. A bit with `bit_vld_i` high in the same cycle as `start_i` is taken as the first bit of the new frame. `mode_i` is sampled with `start_i`: 0 selects generate and 1 selects check.
- R3: Each accepted bit is shifted in most significant first. The bit leaving position n-1 selects whether the low n bits of the polynomial are XORed into the shifted register.
- R4: In generate mode, the bit accepted with `eof_i` high is the last message bit. The block then makes n internal zero shifts. `done_o` is high for exactly one cycle, and it becomes visible n edges after the edge that sampled the last message bit.
- R5: With the default polynomial 110101, the message 1010001101 yields the remainder 01110.
- R6: In check mode, `done_o` becomes visible on the edge that samples the last frame bit. At that point `err_o` is 1 exactly when the remainder is nonzero. A valid frame such as 101000110101110 leaves 00000.
- R7: After `done_o`, both `rem_o` and `err_o` hold until the next `start_i`. Valid bits arriving during this time are ignored.
- R8: A cycle with `bit_vld_i` low does not shift the register. Gaps inside a frame do not change the result.
- R9: Bits presented while the internal zero shifts are running are ignored.
- R10: `err_o` stays 0 in generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the register and begins a frame |
| mode_i | input | 1 | Sampled with start: 0 generate, 1 check |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifies bit_i |
| eof_i | input | 1 | Marks the current valid bit as the last of the frame |
| rem_o | output | POLY_W | Current register content; the remainder once done |
| done_o | output | 1 | One-cycle pulse when the remainder is final |
| err_o | output | 1 | Check-mode result, held until the next start |

## Verification
Two events can fall in the same cycle: a new start and a valid data bit. The bench drives `start_i` together with the first message bit of the worked example. It then requires the same remainder and the same `done_o` timing as when the start stands alone, which shows that the clear and the first shift merge into one edge. A second pair is accepted-looking input during the zero flush and the hold. The bench keeps `bit_vld_i` high through those cycles on half of the exhaustive sweep, and it judges the result by comparing the remainder against arithmetic polynomial division done in the bench. It also confirms that the remainder stays unchanged one cycle after `done_o`.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RECV  = 2'd1,
      ST_FLUSH = 2'd2,
      ST_HOLD  = 2'd3
   } crc_state_e;

   typedef enum logic {
      MODE_GEN = 1'b0,
      MODE_CHK = 1'b1
   } crc_mode_e;

endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
   parameter int           W    = 5,
   parameter logic [W:0]   POLY = 6'b110101
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         shift_i,
   input  logic         din_i,
   output logic [W-1:0] state_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic         fb;

   assign base = clr_i ? '0 : state_q;
   assign fb   = base[W-1];

   for (genvar i = 0; i < W; i++) begin : g_tap
      logic src;
      if (i == 0) begin : g_in
         assign src = din_i;
      end else begin : g_mid
         assign src = base[i-1];
      end
      if (POLY[i]) begin : g_xor
         assign nxt[i] = src ^ fb;
      end else begin : g_pass
         assign nxt[i] = src;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (shift_i) begin
         state_q <= nxt;
      end else if (clr_i) begin
         state_q <= '0;
      end
   end

   assign state_o = state_q;

   p_idle_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !shift_i) |=> $stable(state_o));

endmodule

// File: rtl/crc_seq.sv
module crc_seq
   import crc_ser_pkg::*;
#(
   parameter int W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic mode_i,
   input  logic bit_vld_i,
   input  logic eof_i,
   output logic clr_o,
   output logic shift_o,
   output logic zero_o,
   output logic done_o,
   output logic hold_o,
   output logic chk_o
);

   localparam int CW = (W > 2) ? $clog2(W) : 2;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   crc_state_e    st_q, st_d;
   crc_mode_e     mode_q, cur_mode;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          done_q, done_d;
   logic          accept, flushing;

   assign cur_mode = start_i ? crc_mode_e'(mode_i) : mode_q;
   assign accept   = bit_vld_i && (start_i || (st_q == ST_RECV));
   assign flushing = (st_q == ST_FLUSH) && !start_i;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      done_d = 1'b0;
      if (accept && eof_i) begin
         cnt_d = '0;
         if (cur_mode == MODE_CHK) begin
            st_d   = ST_HOLD;
            done_d = 1'b1;
         end else begin
            st_d = ST_FLUSH;
         end
      end else if (start_i) begin
         st_d  = ST_RECV;
         cnt_d = '0;
      end else if (flushing) begin
         if (cnt_q == LAST) begin
            st_d   = ST_HOLD;
            done_d = 1'b1;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= MODE_GEN;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         done_q <= done_d;
         if (start_i) mode_q <= crc_mode_e'(mode_i);
      end
   end

   assign clr_o   = start_i;
   assign shift_o = accept || flushing;
   assign zero_o  = flushing;
   assign done_o  = done_q;
   assign hold_o  = (st_q == ST_HOLD);
   assign chk_o   = (mode_q == MODE_CHK);

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   p_flush_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_FLUSH) && !start_i) |=> (st_q == ST_FLUSH || st_q == ST_HOLD));

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
   parameter int                POLY_W = 5,
   parameter logic [POLY_W:0]   POLY   = 6'b110101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic              bit_i,
   input  logic              bit_vld_i,
   input  logic              eof_i,
   output logic [POLY_W-1:0] rem_o,
   output logic              done_o,
   output logic              err_o
);

   if (POLY_W < 3 || POLY_W > 32) begin : g_bad_width
      $error("crc_serial_unit: POLY_W must lie in 3..32");
   end
   if (!POLY[POLY_W]) begin : g_bad_poly
      $error("crc_serial_unit: top polynomial bit must be set");
   end

   logic clr, shift, zero, hold, chk, din;

   crc_seq #(.W(POLY_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mode_i    (mode_i),
      .bit_vld_i (bit_vld_i),
      .eof_i     (eof_i),
      .clr_o     (clr),
      .shift_o   (shift),
      .zero_o    (zero),
      .done_o    (done_o),
      .hold_o    (hold),
      .chk_o     (chk)
   );

   assign din = zero ? 1'b0 : bit_i;

   crc_lfsr #(.W(POLY_W), .POLY(POLY)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .shift_i (shift),
      .din_i   (din),
      .state_o (rem_o)
   );

   assign err_o = hold && chk && (|rem_o);

   p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !bit_vld_i) |=> (rem_o == '0));

   p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !start_i) |=> ($stable(rem_o) && $stable(err_o)));

   p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o);

   p_gen_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk) |-> !err_o);

endmodule

// File: tb/crc_serial_unit_bench.sv
module crc_serial_unit_bench;

   localparam logic [5:0] POLY_B = 6'b110101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, mode_i = 1'b0, bit_i = 1'b0;
   logic       bit_vld_i = 1'b0, eof_i = 1'b0;
   logic [4:0] rem_o;
   logic       done_o, err_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   crc_serial_unit u_crc_serial_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .bit_i(bit_i), .bit_vld_i(bit_vld_i), .eof_i(eof_i),
      .rem_o(rem_o), .done_o(done_o), .err_o(err_o)
   );

   function automatic logic [4:0] ref_rem(logic [15:0] v, int nb);
      for (int i = nb - 1; i >= 5; i--)
         if (v[i]) v = v ^ (16'(POLY_B) << (i - 5));
      return v[4:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_frame(input bit chk, input logic [15:0] data, input int nb,
                            input bit gaps, input bit junk, input bit on_start,
                            input logic [4:0] exp_rem);
      int first;
      int got;
      logic [4:0] saved;
      got = 0;
      saved = '0;
      @(negedge clk);
      start_i = 1'b1; mode_i = chk;
      first = on_start ? 1 : 0;
      if (on_start) begin
         bit_vld_i = 1'b1; bit_i = data[nb-1]; eof_i = (nb == 1);
      end else begin
         bit_vld_i = 1'b0; eof_i = 1'b0;
      end
      for (int i = first; i < nb; i++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (gaps && (i % 2 == 1)) begin
            bit_vld_i = 1'b0; eof_i = 1'b0; bit_i = ~data[nb-1-i];
            @(negedge clk);
         end
         bit_vld_i = 1'b1; bit_i = data[nb-1-i]; eof_i = (i == nb - 1);
      end
      for (int c = 1; c <= 40 && got == 0; c++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (done_o) begin
            got = c;
            saved = rem_o;
            check(chk ? "R6 remainder" : "R3 remainder", 32'(rem_o), 32'(exp_rem));
            check(chk ? "R6 error flag" : "R10 error flag", 32'(err_o),
                  32'(chk && (exp_rem != 0)));
         end
         bit_vld_i = junk; bit_i = 1'b1; eof_i = 1'b0;
      end
      check(chk ? "R6 done latency" : "R4 done latency", 32'(got), chk ? 32'd1 : 32'd6);
      @(negedge clk);
      check("R4 done single pulse", 32'(done_o), 32'd0);
      check("R7 remainder held", 32'(rem_o), 32'(saved));
      bit_vld_i = 1'b0; bit_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] frame;
      logic [4:0]  c5;
      repeat (3) @(negedge clk);
      check("R1 reset rem", 32'(rem_o), 32'd0);
      check("R1 reset done", 32'(done_o), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle rem", 32'(rem_o), 32'd0);
      check("R1 idle err", 32'(err_o), 32'd0);

      // R5 worked example, generate
      run_frame(1'b0, 16'b1010001101, 10, 1'b0, 1'b0, 1'b0, 5'b01110);
      // R2 start coincident with first bit
      run_frame(1'b0, 16'b1010001101, 10, 1'b0, 1'b1, 1'b1, 5'b01110);
      // R6 worked frame, check
      run_frame(1'b1, 16'b101000110101110, 15, 1'b1, 1'b1, 1'b0, 5'b00000);
      frame = 16'b101000110101110 ^ 16'h0100;
      run_frame(1'b1, frame, 15, 1'b0, 1'b0, 1'b0, ref_rem(frame, 15));

      // exhaustive sweep: R3 R8 R9 generate, R6 R7 check
      for (int len = 1; len <= 8; len++) begin
         for (int m = 0; m < (1 << len); m++) begin
            logic [15:0] msg;
            msg = 16'(m);
            c5  = ref_rem(msg << 5, len + 5);
            run_frame(1'b0, msg, len, msg[1], msg[0], 1'b0, c5);
            frame = (msg << 5) | 16'(c5);
            run_frame(1'b1, frame, len + 5, msg[0], msg[1], 1'b0, 5'b0);
            frame = frame ^ (16'h1 << (m % (len + 5)));
            run_frame(1'b1, frame, len + 5, 1'b0, 1'b1, 1'b0, ref_rem(frame, len + 5));
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule